// File: doc/BRIEF.md
# Ethernet MAC interrupt status controller

This block gathers single-cycle event pulses from a small Ethernet MAC's receive path, transmit path, management interface and PHY, and holds them in a raw status register. A mask register chooses which held events may raise the single interrupt line. Software reads both registers over a simple register bus. It acknowledges events by writing ones to the status word and rewrites the mask at will.

Several distinct receive faults share one error bit. Transmit problems also share one bit. The transmit problems come from two checks inside the block: a frame length limit applied when a frame starts, and a collision-retry counter. Acknowledging the transmit-error bit has a side effect. It emits a one-cycle pulse that tells the transmit FIFO to rewind its write pointer, which discards the rejected frame.

Top module: `irqc_ctrl`

## Requirements
- R1: After reset the status word reads 0, the mask reads 0x7F, and `irq`, `txfifo_wptr_rst` and `tx_frame_reject` are low.
- R2: Each source sets its own status bit, visible on the bus the cycle after the event: bit 0 `rx_pkt_done`, bit 3 `rx_fifo_ovf`, bit 5 `mgmt_done`, bit 6 `phy_event`. Bits 1, 2 and 4 are described below.
- R3: Status bit 4 is set by `rx_dribble`, `rx_fcs_bad` or `rx_len_mismatch`, or by `rx_phy_err` only while `rx_speed_100` is high. `rx_phy_err` with `rx_speed_100` low has no effect.
- R4: When `tx_frame_start` comes with `tx_len_field` above 2032, `tx_frame_reject` is high in that same cycle and status bit 1 sets. A length of exactly 2032 is accepted.
- R5: A retry counter clears on `tx_frame_start` or `tx_done_ok`, and otherwise counts each `tx_collision`. A collision arriving while the counter already holds 16 (the 17th of the frame) sets status bit 1 and clears the counter. A collision in the same cycle as a start or a done is not counted.
- R6: Status bit 2 sets only when `tx_done_ok` and `tx_fifo_empty` are high together.
- R7: A bus write to word address 0 clears every status bit whose data bit is 1. Data bits that are 0 leave their status bits unchanged.
- R8: If a bit's set event and its write-1 clear fall in the same cycle, the bit ends up set.
- R9: A status write with data bit 1 set drives `txfifo_wptr_rst` high for exactly the next cycle. This happens whether or not status bit 1 was set.
- R10: Word address 1 holds the mask in bits 6:0, and writes load those bits. Bits 31:7 of any read are 0, and word addresses 2 and 3 read 0. Reads are combinational from `bus_addr`.
- R11: `irq` equals the OR of (status AND mask) as it stood in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register bus select |
| bus_wr | input | 1 | Write strobe (with bus_sel) |
| bus_addr | input | 2 | Word address: 0 status, 1 mask |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| rx_pkt_done | input | 1 | A frame was stored in the receive FIFO |
| rx_speed_100 | input | 1 | Link runs at 100 Mbps |
| rx_phy_err | input | 1 | PHY flagged a receive error during a frame |
| rx_dribble | input | 1 | Frame was not a whole number of bytes |
| rx_fcs_bad | input | 1 | Frame check sequence failed |
| rx_len_mismatch | input | 1 | Length/type disagrees with data size |
| rx_fifo_ovf | input | 1 | Receive FIFO overran |
| tx_frame_start | input | 1 | A transmit frame begins |
| tx_len_field | input | 12 | Length field of that frame |
| tx_collision | input | 1 | Collision; backoff retry follows |
| tx_done_ok | input | 1 | Frame sent successfully |
| tx_fifo_empty | input | 1 | Transmit FIFO is empty |
| mgmt_done | input | 1 | Management transaction finished |
| phy_event | input | 1 | PHY interrupt |
| irq | output | 1 | Interrupt request |
| txfifo_wptr_rst | output | 1 | Pulse: rewind transmit FIFO write pointer |
| tx_frame_reject | output | 1 | Current starting frame must not be sent |

## Verification
Two things can land on one status bit in the same cycle: a new event from a source and a software acknowledge of that bit. A second such pair is a collision arriving together with a frame start, which also clears the retry counter. The bench forces both pairs in directed steps and also lets them arise freely under random traffic. A behavioural model judges each outcome on every clock: set must beat clear, and the start must win so that the collision is not counted.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   localparam int N_SRC = 7;
   // status bit positions (software decodes these)
   localparam int B_RXPKT = 0;
   localparam int B_TXERR = 1;
   localparam int B_TXEMP = 2;
   localparam int B_RXOVF = 3;
   localparam int B_RXERR = 4;
   localparam int B_MGMT  = 5;
   localparam int B_PHY   = 6;
   // word addresses
   localparam int ADR_STATUS = 0;
   localparam int ADR_MASK   = 1;
   typedef logic [N_SRC-1:0] src_vec_t;
endpackage

// File: rtl/irqc_status_bit.sv
module irqc_status_bit (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   always_ff @(posedge clk) begin
      if (!rst_n)     q_o <= 1'b0;
      else if (set_i) q_o <= 1'b1;
      else if (clr_i) q_o <= 1'b0;
   end

   // set beats a same-cycle acknowledge
   assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> q_o);
   // a lone acknowledge clears
   assert_w1c_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> !q_o);
endmodule

// File: rtl/irqc_tx_check.sv
module irqc_tx_check #(
   parameter int LEN_W       = 12,
   parameter int MAX_LEN     = 2032,
   parameter int RETRY_LIMIT = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_start,
   input  logic [LEN_W-1:0] len_field,
   input  logic             collision,
   input  logic             done_ok,
   output logic             len_err,
   output logic             retry_err
);
   localparam int CNT_W = $clog2(RETRY_LIMIT + 1);

   logic [CNT_W-1:0] retry_cnt;
   logic             restart;

   assign restart   = frame_start | done_ok;
   assign len_err   = frame_start && (len_field > LEN_W'(MAX_LEN));
   assign retry_err = collision && !restart && (retry_cnt == CNT_W'(RETRY_LIMIT));

   always_ff @(posedge clk) begin
      if (!rst_n)         retry_cnt <= '0;
      else if (restart)   retry_cnt <= '0;
      else if (retry_err) retry_cnt <= '0;
      else if (collision) retry_cnt <= retry_cnt + 1'b1;
   end

   assert_cnt_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
      retry_cnt <= CNT_W'(RETRY_LIMIT));
   assert_cnt_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (retry_cnt == '0));
endmodule

// File: rtl/irqc_ctrl.sv
module irqc_ctrl #(
   parameter int DATA_W         = 32,
   parameter int ADDR_W         = 2,
   parameter int LEN_W          = 12,
   parameter int MAX_FRAME_LEN  = 2032,
   parameter int RETRY_LIMIT    = 16,
   parameter bit IRQ_REGISTERED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              rx_pkt_done,
   input  logic              rx_speed_100,
   input  logic              rx_phy_err,
   input  logic              rx_dribble,
   input  logic              rx_fcs_bad,
   input  logic              rx_len_mismatch,
   input  logic              rx_fifo_ovf,
   input  logic              tx_frame_start,
   input  logic [LEN_W-1:0]  tx_len_field,
   input  logic              tx_collision,
   input  logic              tx_done_ok,
   input  logic              tx_fifo_empty,
   input  logic              mgmt_done,
   input  logic              phy_event,
   output logic              irq,
   output logic              txfifo_wptr_rst,
   output logic              tx_frame_reject
);
   import irqc_pkg::*;

   if (DATA_W < N_SRC) begin : g_bad_data_w
      $error("DATA_W must hold all status bits");
   end
   if (ADDR_W < 1) begin : g_bad_addr_w
      $error("ADDR_W must be at least 1");
   end
   if (MAX_FRAME_LEN >= (1 << LEN_W)) begin : g_bad_len
      $error("MAX_FRAME_LEN must fit in LEN_W bits");
   end
   if (RETRY_LIMIT < 1) begin : g_bad_retry
      $error("RETRY_LIMIT must be positive");
   end

   src_vec_t raw_q, mask_q, set_v, clr_v;
   logic     status_wr, mask_wr, len_err, retry_err, wptr_q;

   assign status_wr = bus_sel && bus_wr && (bus_addr == ADDR_W'(ADR_STATUS));
   assign mask_wr   = bus_sel && bus_wr && (bus_addr == ADDR_W'(ADR_MASK));

   irqc_tx_check #(
      .LEN_W(LEN_W), .MAX_LEN(MAX_FRAME_LEN), .RETRY_LIMIT(RETRY_LIMIT)
   ) u_txchk (
      .clk(clk), .rst_n(rst_n), .frame_start(tx_frame_start),
      .len_field(tx_len_field), .collision(tx_collision), .done_ok(tx_done_ok),
      .len_err(len_err), .retry_err(retry_err)
   );

   assign tx_frame_reject = len_err;

   always_comb begin
      set_v          = '0;
      set_v[B_RXPKT] = rx_pkt_done;
      set_v[B_TXERR] = len_err | retry_err;
      set_v[B_TXEMP] = tx_done_ok & tx_fifo_empty;
      set_v[B_RXOVF] = rx_fifo_ovf;
      set_v[B_RXERR] = (rx_phy_err & rx_speed_100) | rx_dribble | rx_fcs_bad | rx_len_mismatch;
      set_v[B_MGMT]  = mgmt_done;
      set_v[B_PHY]   = phy_event;
      clr_v          = status_wr ? bus_wdata[N_SRC-1:0] : '0;
   end

   for (genvar i = 0; i < N_SRC; i++) begin : g_bit
      irqc_status_bit u_bit (
         .clk(clk), .rst_n(rst_n), .set_i(set_v[i]), .clr_i(clr_v[i]), .q_o(raw_q[i])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q <= '1;
         wptr_q <= 1'b0;
      end else begin
         if (mask_wr) mask_q <= bus_wdata[N_SRC-1:0];
         wptr_q <= status_wr && bus_wdata[B_TXERR];
      end
   end
   assign txfifo_wptr_rst = wptr_q;

   if (IRQ_REGISTERED) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= |(raw_q & mask_q);
      end
      assign irq = irq_q;
   end else begin : g_irq_comb
      assign irq = |(raw_q & mask_q);
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(ADR_STATUS))    bus_rdata[N_SRC-1:0] = raw_q;
      else if (bus_addr == ADDR_W'(ADR_MASK)) bus_rdata[N_SRC-1:0] = mask_q;
   end

   always_comb begin
      assert_upper_zero_R10: assert (bus_rdata[DATA_W-1:N_SRC] == '0);
   end
   assert_wptr_after_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (status_wr && bus_wdata[B_TXERR]) |=> txfifo_wptr_rst);
   assert_wptr_only_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
      txfifo_wptr_rst |-> $past(status_wr && bus_wdata[B_TXERR]));
   assert_reject_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
      tx_frame_reject |=> raw_q[B_TXERR]);
endmodule

// File: tb/sim_irqc_ctrl.sv
`timescale 1ns/1ps
module sim_irqc_ctrl;
   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic        rst_n, bus_sel, bus_wr;
   logic [1:0]  bus_addr;
   logic [31:0] bus_wdata, bus_rdata;
   logic rx_pkt_done, rx_speed_100, rx_phy_err, rx_dribble, rx_fcs_bad, rx_len_mismatch, rx_fifo_ovf;
   logic tx_frame_start, tx_collision, tx_done_ok, tx_fifo_empty, mgmt_done, phy_event;
   logic [11:0] tx_len_field;
   logic irq, txfifo_wptr_rst, tx_frame_reject;

   irqc_ctrl u0 (.*);

   int    n_vec = 0, n_bad = 0;
   string cur_req = "R1";
   bit    finished = 0;

   // behavioural reference state
   logic [6:0] m_raw, m_mask;
   logic       m_irq, m_wptr;
   int         m_cnt;

   task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
      end
   endtask

   task automatic idle();
      bus_sel = 0; bus_wr = 0; bus_wdata = '0;
      rx_pkt_done = 0; rx_speed_100 = 1; rx_phy_err = 0; rx_dribble = 0;
      rx_fcs_bad = 0; rx_len_mismatch = 0; rx_fifo_ovf = 0;
      tx_frame_start = 0; tx_len_field = '0; tx_collision = 0; tx_done_ok = 0;
      tx_fifo_empty = 0; mgmt_done = 0; phy_event = 0;
   endtask

   // check this cycle, advance the model across one clock edge
   task automatic step();
      logic [31:0] e_rd;
      logic [6:0]  set, clr, n_raw, n_mask;
      logic        wr0, wr1, lerr, rerr, n_irq, n_wptr;
      int          n_cnt;
      #1;
      e_rd = (bus_addr == 0) ? {25'b0, m_raw} : (bus_addr == 1) ? {25'b0, m_mask} : 32'b0;
      lerr = tx_frame_start && (int'(tx_len_field) > 2032);
      chk("rdata", bus_rdata, e_rd);
      chk("irq", {31'b0, irq}, {31'b0, m_irq});
      chk("wptr_rst", {31'b0, txfifo_wptr_rst}, {31'b0, m_wptr});
      chk("reject", {31'b0, tx_frame_reject}, {31'b0, lerr});
      wr0 = bus_sel && bus_wr && bus_addr == 0;
      wr1 = bus_sel && bus_wr && bus_addr == 1;
      rerr = 0; n_cnt = m_cnt;
      if (tx_frame_start || tx_done_ok) n_cnt = 0;
      else if (tx_collision) begin
         if (m_cnt == 16) begin rerr = 1; n_cnt = 0; end
         else n_cnt = m_cnt + 1;
      end
      set = {phy_event, mgmt_done,
             (rx_phy_err && rx_speed_100) || rx_dribble || rx_fcs_bad || rx_len_mismatch,
             rx_fifo_ovf, tx_done_ok && tx_fifo_empty, lerr || rerr, rx_pkt_done};
      clr    = wr0 ? bus_wdata[6:0] : 7'b0;
      n_raw  = set | (m_raw & ~clr);
      n_mask = wr1 ? bus_wdata[6:0] : m_mask;
      n_irq  = |(m_raw & m_mask);
      n_wptr = wr0 && bus_wdata[1];
      @(posedge clk);
      m_raw = n_raw; m_mask = n_mask; m_irq = n_irq; m_wptr = n_wptr; m_cnt = n_cnt;
      @(negedge clk);
      idle();
   endtask

   task automatic write(logic [1:0] a, logic [31:0] d);
      bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
      step();
   endtask

   task automatic look(logic [1:0] a);
      bus_addr = a;
      step();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_vec++; n_bad++;
         $display("FAIL watchdog expired actual=hung expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      idle(); bus_addr = 0; rst_n = 0;
      m_raw = 0; m_mask = 7'h7F; m_irq = 0; m_wptr = 0; m_cnt = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      cur_req = "R1"; look(0); look(1);

      cur_req = "R2";
      rx_pkt_done = 1; step(); look(0);
      rx_fifo_ovf = 1; step(); mgmt_done = 1; step(); phy_event = 1; step(); look(0);

      cur_req = "R11"; look(0); look(0);
      write(1, 32'h0); look(0); look(0);
      write(1, 32'h7F); look(0); look(0);

      cur_req = "R7";
      write(0, 32'h0); look(0);
      write(0, 32'h21); look(0);
      write(0, 32'hFFFF_FFFF); look(0); look(0);

      cur_req = "R3";
      rx_speed_100 = 0; rx_phy_err = 1; step(); look(0);
      rx_phy_err = 1; step(); look(0); write(0, 32'h10);
      rx_dribble = 1; step(); look(0); write(0, 32'h10);
      rx_fcs_bad = 1; step(); look(0); write(0, 32'h10);
      rx_len_mismatch = 1; step(); look(0); write(0, 32'h10); look(0);

      cur_req = "R4";
      tx_frame_start = 1; tx_len_field = 12'd2032; step(); look(0);
      tx_frame_start = 1; tx_len_field = 12'd2033; step(); look(0);
      cur_req = "R9";
      write(0, 32'h2); look(0); look(0);
      write(0, 32'h2); write(0, 32'h2); look(0);

      cur_req = "R5";
      tx_frame_start = 1; tx_len_field = 12'd64; step();
      for (int i = 0; i < 16; i++) begin tx_collision = 1; step(); end
      look(0);
      tx_collision = 1; step(); look(0); write(0, 32'h2);
      tx_frame_start = 1; tx_collision = 1; step();
      for (int i = 0; i < 16; i++) begin tx_collision = 1; step(); end
      tx_done_ok = 1; tx_collision = 1; step();
      tx_collision = 1; step(); look(0);

      cur_req = "R6";
      tx_done_ok = 1; step(); look(0);
      tx_fifo_empty = 1; step(); look(0);
      tx_done_ok = 1; tx_fifo_empty = 1; step(); look(0); write(0, 32'h4);

      cur_req = "R8";
      rx_pkt_done = 1; bus_sel = 1; bus_wr = 1; bus_addr = 0; bus_wdata = 32'h1; step(); look(0);
      rx_fifo_ovf = 1; bus_sel = 1; bus_wr = 1; bus_addr = 0; bus_wdata = 32'h9; step(); look(0);

      cur_req = "R10";
      write(1, 32'hFFFF_FF05); look(1); look(2); look(3);
      write(2, 32'hFFFF_FFFF); look(1); look(0);

      cur_req = "R11";
      for (int i = 0; i < 4000; i++) begin
         rx_pkt_done     = ($urandom_range(0, 15) == 0);
         rx_speed_100    = $urandom_range(0, 1);
         rx_phy_err      = ($urandom_range(0, 15) == 0);
         rx_dribble      = ($urandom_range(0, 31) == 0);
         rx_fcs_bad      = ($urandom_range(0, 31) == 0);
         rx_len_mismatch = ($urandom_range(0, 31) == 0);
         rx_fifo_ovf     = ($urandom_range(0, 31) == 0);
         tx_frame_start  = ($urandom_range(0, 31) == 0);
         tx_len_field    = 12'($urandom_range(2000, 2063));
         tx_collision    = ($urandom_range(0, 1) == 0);
         tx_done_ok      = ($urandom_range(0, 31) == 0);
         tx_fifo_empty   = $urandom_range(0, 1);
         mgmt_done       = ($urandom_range(0, 31) == 0);
         phy_event       = ($urandom_range(0, 31) == 0);
         bus_sel         = ($urandom_range(0, 3) == 0);
         bus_wr          = ($urandom_range(0, 1) == 0);
         bus_addr        = 2'($urandom_range(0, 3));
         bus_wdata       = $urandom;
         step();
      end

      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule